// File: doc/BRIEF.md
# Restart Modification Log

This block is a pair of status registers that sit in a memory-management unit. The first register records which general registers the current instruction has already auto-incremented or auto-decremented, and by how much. The second register holds the virtual PC of the instruction's first word. After a page fault, handler software reads both registers, reverses the register side effects, and restarts the instruction. The most common use is extending a stack on demand.

The execution unit drives a few event inputs: an instruction-start strobe with its PC, a register-modified strobe with a register number and a signed delta, and a fault strobe. A fault freezes both registers. They stay frozen while software examines them. A release input unfreezes them, and tracking restarts at the next instruction start. Software reads both registers through a small memory-mapped port. Writes to them are ignored. A build parameter removes the tracking feature, and the tracking register then reads as zero.

Top module: `mmu_restart_log`

## Requirements
- R1: After reset, both registers read zero and `frozen_o` is low.
- R2: An instruction start while not frozen clears the modification log and loads `insn_pc_i` into the PC register. Both values are visible from the next cycle.
- R3: The first register modified by an instruction occupies the low slot of the log word: bits 2:0 hold the register number and bits 7:3 hold the 5-bit two's-complement delta. A single event with delta -4 (a double-word push) reads as 5'b11100.
- R4: A second, different register occupies the high slot: bits 10:8 hold the register number and bits 15:11 hold the delta. The high slot is never filled while the low slot is empty. An empty slot reads as all zeros.
- R5: A further change to a register that already has a slot adds to that slot's delta with 5-bit wrap. For example, two -2 changes to one register read as -4.
- R6: A modification in the same cycle as the fault strobe is recorded. After the fault, `frozen_o` is high, and instruction starts, modifications and further faults change neither register.
- R7: `release_i` while frozen clears `frozen_o` without changing the registers. Modifications that arrive before the next instruction start are ignored. That start clears the log and loads the PC as in R2.
- R8: The log word is at byte address 16'o177574 and the PC register at 16'o177576. Bus writes change nothing. A read of any other address returns zero.
- R9: With `TRACK_EN` = 0, the log word reads zero at all times, while the PC register behaves as in R2.
- R10: A modification of a third distinct register within one instruction is dropped, and both slots keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| insn_start_i | input | 1 | First cycle of a new instruction |
| insn_pc_i | input | 16 | Virtual PC of the instruction's first word |
| reg_mod_i | input | 1 | A general register was changed this cycle |
| reg_num_i | input | 3 | Number of the changed register |
| reg_delta_i | input | 5 | Signed amount of the change |
| fault_i | input | 1 | Abort/fault strobe from translation |
| release_i | input | 1 | Software release of the frozen state |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Access is a write (ignored) |
| bus_addr_i | input | 16 | Byte address of the access |
| bus_rdata_o | output | 16 | Read data, combinational |
| frozen_o | output | 1 | Registers are held after a fault |

## Verification
The bench sweeps every register number against every nonzero delta. It then sweeps every ordered register pair. A design with a misplaced field or a wrong sign encoding fails the first sweep. A design that puts a repeated register into a new slot, instead of accumulating, fails the diagonal of the pair sweep. The fault sequence checks that a change made in the same cycle as the fault is kept, and that starts, changes and faults during the frozen period are ignored. A design that resumes tracking on release, rather than at the next start, logs a stray change. Further tests check that a third distinct register is dropped and that writes to the bus are ignored. A second instance without the feature must read zero where the first instance reports a delta.

// File: rtl/mmu_rlog_pkg.sv
package mmu_rlog_pkg;
  parameter int unsigned REG_W  = 3;
  parameter int unsigned DLT_W  = 5;
  parameter int unsigned NSLOT  = 2;
  parameter int unsigned ADDR_W = 16;
  localparam int unsigned SLOT_W = REG_W + DLT_W;
  localparam int unsigned LOG_W  = NSLOT * SLOT_W;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HELD = 2'd1,
    ST_WAIT = 2'd2
  } rlog_state_e;

  typedef struct packed {
    logic             vld;
    logic [REG_W-1:0] rnum;
    logic [DLT_W-1:0] dlt;
  } rlog_slot_t;
endpackage

// File: rtl/mmu_rlog_freeze.sv
module mmu_rlog_freeze
  import mmu_rlog_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic insn_start_i,
  input  logic fault_i,
  input  logic release_i,
  output logic upd_en_o,
  output logic clr_o,
  output logic frozen_o,
  output logic wait_o
);
  rlog_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (fault_i) state_d = ST_HELD;
      ST_HELD: if (release_i) state_d = ST_WAIT;
      ST_WAIT: if (insn_start_i) state_d = fault_i ? ST_HELD : ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  // tracking is live in RUN, or in WAIT from the cycle of the next start
  assign upd_en_o = (state_q == ST_RUN) || ((state_q == ST_WAIT) && insn_start_i);
  assign clr_o    = insn_start_i && (state_q != ST_HELD);
  assign frozen_o = (state_q == ST_HELD);
  assign wait_o   = (state_q == ST_WAIT);

  p_state_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) || (state_q == ST_HELD) || (state_q == ST_WAIT));
endmodule

// File: rtl/mmu_rlog_slots.sv
module mmu_rlog_slots
  import mmu_rlog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_en_i,
  input  logic             clr_i,
  input  logic             mod_i,
  input  logic [REG_W-1:0] rnum_i,
  input  logic [DLT_W-1:0] delta_i,
  output logic [LOG_W-1:0] log_o
);
  rlog_slot_t [NSLOT-1:0] slot_q, slot_d, base;
  logic [NSLOT-1:0] hit, free;
  logic found, got_free;

  always_comb begin
    base     = clr_i ? '0 : slot_q;
    hit      = '0;
    free     = '0;
    found    = 1'b0;
    got_free = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (!found && base[i].vld && base[i].rnum == rnum_i) begin
        hit[i] = 1'b1;
        found  = 1'b1;
      end
    end
    for (int i = 0; i < NSLOT; i++) begin
      if (!found && !got_free && !base[i].vld) begin
        free[i]  = 1'b1;
        got_free = 1'b1;
      end
    end
    slot_d = base;
    if (mod_i) begin
      for (int i = 0; i < NSLOT; i++) begin
        if (hit[i])       slot_d[i].dlt = base[i].dlt + delta_i;
        else if (free[i]) slot_d[i] = '{vld: 1'b1, rnum: rnum_i, dlt: delta_i};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       slot_q <= '0;
    else if (upd_en_i) slot_q <= slot_d;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_pack
    assign log_o[g*SLOT_W +: REG_W]         = slot_q[g].vld ? slot_q[g].rnum : '0;
    assign log_o[g*SLOT_W + REG_W +: DLT_W] = slot_q[g].vld ? slot_q[g].dlt  : '0;
    if (g > 0) begin : g_ord
      p_slot_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !slot_q[g-1].vld |-> !slot_q[g].vld);
    end
  end

  p_third_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !clr_i && mod_i && (&{slot_q[0].vld, slot_q[NSLOT-1].vld})
     && !(|hit)) |=> $stable(slot_q));
endmodule

// File: rtl/mmu_rlog_pcreg.sv
module mmu_rlog_pcreg
  import mmu_rlog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_o <= '0;
    else if (cap_i) pc_o <= pc_i;
  end
endmodule

// File: rtl/mmu_rlog_bus.sv
module mmu_rlog_bus
  import mmu_rlog_pkg::*;
#(
  parameter logic [ADDR_W-1:0] LOG_ADDR = 16'o177574,
  parameter logic [ADDR_W-1:0] PC_ADDR  = 16'o177576
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LOG_W-1:0]  log_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (sel_i && !we_i) begin
      if (addr_i == LOG_ADDR)     rdata_o = ADDR_W'(log_i);
      else if (addr_i == PC_ADDR) rdata_o = pc_i;
    end
  end
endmodule

// File: rtl/mmu_restart_log.sv
module mmu_restart_log
  import mmu_rlog_pkg::*;
#(
  parameter bit                TRACK_EN = 1'b1,
  parameter logic [ADDR_W-1:0] LOG_ADDR = 16'o177574,
  parameter logic [ADDR_W-1:0] PC_ADDR  = 16'o177576
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              insn_start_i,
  input  logic [ADDR_W-1:0] insn_pc_i,
  input  logic              reg_mod_i,
  input  logic [REG_W-1:0]  reg_num_i,
  input  logic [DLT_W-1:0]  reg_delta_i,
  input  logic              fault_i,
  input  logic              release_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic [ADDR_W-1:0] bus_rdata_o,
  output logic              frozen_o
);
  logic upd_en, clr, waiting;
  logic [LOG_W-1:0]  log_word;
  logic [ADDR_W-1:0] pc_q;

  mmu_rlog_freeze u_freeze (
    .clk_i, .rst_ni, .insn_start_i, .fault_i, .release_i,
    .upd_en_o(upd_en), .clr_o(clr), .frozen_o(frozen_o), .wait_o(waiting)
  );

  if (TRACK_EN) begin : g_track
    mmu_rlog_slots u_slots (
      .clk_i, .rst_ni, .upd_en_i(upd_en), .clr_i(clr), .mod_i(reg_mod_i),
      .rnum_i(reg_num_i), .delta_i(reg_delta_i), .log_o(log_word)
    );
  end else begin : g_notrack
    assign log_word = '0;
    logic unused_mod;
    assign unused_mod = ^{reg_mod_i, reg_num_i, reg_delta_i};
  end

  mmu_rlog_pcreg u_pc (
    .clk_i, .rst_ni, .cap_i(clr), .pc_i(insn_pc_i), .pc_o(pc_q)
  );

  mmu_rlog_bus #(.LOG_ADDR(LOG_ADDR), .PC_ADDR(PC_ADDR)) u_bus (
    .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .log_i(log_word), .pc_i(pc_q), .rdata_o(bus_rdata_o)
  );

  p_start_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_start_i && !frozen_o && !reg_mod_i) |=> (log_word == '0) && (pc_q == $past(insn_pc_i)));

  p_fault_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && upd_en) |=> frozen_o);

  p_held_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o && !release_i) |=> frozen_o && $stable(log_word) && $stable(pc_q));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o && release_i) |=> !frozen_o && $stable(log_word) && $stable(pc_q));

  p_wait_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waiting && !insn_start_i) |=> $stable(log_word));
endmodule

// File: tb/sim_mmu_restart_log.sv
module sim_mmu_restart_log;
  logic clk = 1'b0, rst_n = 1'b0;
  logic st = 1'b0, mv = 1'b0, flt = 1'b0, rel = 1'b0, sel = 1'b0, we = 1'b0;
  logic [15:0] pc = '0, addr = '0;
  logic [2:0]  rn = '0;
  logic [4:0]  dl = '0;
  logic [15:0] rd0, rd1;
  logic        frz0, frz1;
  int nvec = 0, nerr = 0;
  localparam logic [15:0] A_LOG = 16'o177574, A_PC = 16'o177576;

  always #10 clk = ~clk;

  mmu_restart_log u0 (
    .clk_i(clk), .rst_ni(rst_n), .insn_start_i(st), .insn_pc_i(pc), .reg_mod_i(mv),
    .reg_num_i(rn), .reg_delta_i(dl), .fault_i(flt), .release_i(rel),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_rdata_o(rd0), .frozen_o(frz0));

  mmu_restart_log #(.TRACK_EN(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .insn_start_i(st), .insn_pc_i(pc), .reg_mod_i(mv),
    .reg_num_i(rn), .reg_delta_i(dl), .fault_i(flt), .release_i(rel),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_rdata_o(rd1), .frozen_o(frz1));

  function automatic logic [15:0] enc(int r0, int d0, bit v0, int r1, int d1, bit v1);
    logic [15:0] w = '0;
    if (v0) begin w[2:0] = 3'(r0); w[7:3] = 5'(d0); end
    if (v1) begin w[10:8] = 3'(r1); w[15:11] = 5'(d1); end
    return w;
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic step(bit s, logic [15:0] p, bit m, int r, int d, bit f, bit rl);
    @(negedge clk);
    st = s; pc = p; mv = m; rn = 3'(r); dl = 5'(d); flt = f; rel = rl;
    @(negedge clk);
    st = 0; mv = 0; flt = 0; rel = 0;
  endtask

  task automatic rd(logic [15:0] a, bit w, output logic [15:0] v0, output logic [15:0] v1);
    sel = 1; we = w; addr = a;
    #1; v0 = rd0; v1 = rd1;
    #1; sel = 0; we = 0;
  endtask

  task automatic chk_log(string req, logic [15:0] exp);
    logic [15:0] a, b;
    rd(A_LOG, 0, a, b);
    chk(req, a, exp);
    chk("R9", b, 16'h0);
  endtask

  task automatic chk_pc(string req, logic [15:0] exp);
    logic [15:0] a, b;
    rd(A_PC, 0, a, b);
    chk(req, a, exp);
    chk("R9 pc", b, exp);
  endtask

  initial begin
    #(20 * 200000);
    nerr++;
    $display("FAIL watchdog got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [15:0] a, b;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_log("R1", 16'h0);
    chk_pc("R1", 16'h0);
    chk("R1 frozen", {15'b0, frz0}, 16'h0);

    // R3 sweep every register and nonzero delta
    for (int r = 0; r < 8; r++) begin
      for (int d = -16; d < 16; d++) begin
        if (d == 0) continue;
        step(1, 16'(16'h1000 + r * 64 + (d + 16) * 2), 0, 0, 0, 0, 0);
        chk_log("R2", 16'h0);
        step(0, 0, 1, r, d, 0, 0);
        chk_log("R3", enc(r, d, 1, 0, 0, 0));
        chk_pc("R2", 16'(16'h1000 + r * 64 + (d + 16) * 2));
      end
    end

    // R4/R5 all ordered register pairs
    for (int r0 = 0; r0 < 8; r0++) begin
      for (int r1 = 0; r1 < 8; r1++) begin
        step(1, 16'h2000, 1, r0, -2, 0, 0);
        step(0, 0, 1, r1, (r0 == r1) ? -2 : 2, 0, 0);
        if (r0 == r1) chk_log("R5", enc(r0, -4, 1, 0, 0, 0));
        else          chk_log("R4", enc(r0, -2, 1, r1, 2, 1));
      end
    end

    // R10 third distinct register dropped, then R5 accumulation on slot 1
    step(1, 16'h2100, 1, 0, 2, 0, 0);
    step(0, 0, 1, 6, -2, 0, 0);
    step(0, 0, 1, 4, -2, 0, 0);
    chk_log("R10", enc(0, 2, 1, 6, -2, 1));
    step(0, 0, 1, 6, -2, 0, 0);
    chk_log("R5", enc(0, 2, 1, 6, -4, 1));

    // R6 double-word push faults on second word: delta -4 logged in fault cycle
    step(1, 16'o1234, 0, 0, 0, 0, 0);
    step(0, 0, 1, 6, -4, 1, 0);
    chk_log("R6", enc(6, -4, 1, 0, 0, 0));
    chk("R6 frozen", {15'b0, frz0}, 16'h1);
    step(1, 16'h3333, 1, 1, 2, 0, 0);
    step(0, 0, 1, 2, -2, 1, 0);
    chk_log("R6 held", enc(6, -4, 1, 0, 0, 0));
    chk_pc("R6 held", 16'o1234);
    chk("R6 frozen", {15'b0, frz0}, 16'h1);

    // R8 writes ignored, other address reads zero
    rd(A_LOG, 1, a, b);
    rd(A_PC, 1, a, b);
    chk_log("R8", enc(6, -4, 1, 0, 0, 0));
    rd(16'o177572, 0, a, b);
    chk("R8 other", a, 16'h0);

    // R7 release; stray change ignored until next start
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R7 frozen", {15'b0, frz0}, 16'h0);
    chk_log("R7", enc(6, -4, 1, 0, 0, 0));
    step(0, 0, 1, 3, 2, 0, 0);
    chk_log("R7 stray", enc(6, -4, 1, 0, 0, 0));
    step(1, 16'o1234, 1, 6, -2, 0, 0);
    chk_log("R7 restart", enc(6, -2, 1, 0, 0, 0));
    chk_pc("R7 restart", 16'o1234);
    step(0, 0, 1, 6, -2, 0, 0);
    chk_log("R7 resume", enc(6, -4, 1, 0, 0, 0));

    // R1 reset mid-run
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    chk_log("R1 rereset", 16'h0);
    chk_pc("R1 rereset", 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule